// File: doc/BRIEF.md
# Comparator Timer Channel

This block is a single event channel of a system timer. A free-running main count arrives from outside. The channel compares that count against a stored comparator and produces a one-clock fire pulse when the comparator comes due. Software reaches the channel through a small write port with three targets: a configuration word, the low half of the comparator and the high half.

The channel works in one of two modes. In one-shot mode it fires once and then stays idle until it is armed again. In periodic mode it adds a programmed period to the comparator after every match, so the next event is always ahead of the count. A 32-bit mode restricts the comparator, the period and the due test to the low half of the count. In 32-bit one-shot mode the channel also fires once when the low half of the count wraps, if that wrap comes before the comparator is reached.

The same comparator address loads either the comparator or the period, depending on the mode and on a set-value bit that clears itself. Routing the fire pulse to an interrupt line and producing the main count are left to neighbouring logic.

Top module: `cmp_channel`

## Requirements
- R1: After reset, cmp_o is all ones and cfg_o is 0. err_o is low, no fire pulse appears, the period is 0 and the wrap flag is clear.
- R2: wr_sel_i selects the write target: 0 is configuration, 1 is the comparator low half and 2 is the comparator high half. In a configuration write, data bit 0 is channel enable, bit 1 is periodic, bit 2 is set-value, bit 3 is 32-bit mode and bit 4 requests level triggering. cfg_o shows bits 3:0 in the same positions. A comparator write updates only the addressed half of the comparator when the channel is in one-shot mode, or in periodic mode with set-value high.
- R3: In periodic mode a low-half write also loads the low half of the period. In periodic mode with set-value low, a low-half write leaves the comparator unchanged, and a high-half write loads only the high half of the period.
- R4: A written period has its top bit of the active width cleared: bit 31 in 32-bit mode, bit 63 otherwise.
- R5: Set-value reads back as 0 after any write to either comparator half.
- R6: A configuration write with bit 3 set cuts the stored comparator and period to their low 32 bits. While 32-bit mode is on, high-half writes are ignored.
- R7: The channel is due when the comparator minus the count is zero or negative as a signed number. The difference is 32 bits wide in 32-bit mode and 64 bits wide otherwise. fire_o pulses for one clock, two clocks after the channel becomes armed and due.
- R8: In periodic mode with a nonzero period, each fire adds the period to the comparator. The channel then keeps adding the period, without further fire pulses, until the comparator is ahead of the count seen at the fire. In 32-bit mode the sum wraps at 32 bits.
- R9: In one-shot mode, or in periodic mode with a zero period, the channel fires once and then stays silent until it is armed again.
- R10: Arming in 32-bit one-shot mode sets a wrap flag when the low half of the count would wrap before reaching the comparator. With the flag set, the channel fires when the low half of the count is all ones, clears the flag, and fires again at the comparator match.
- R11: Fire pulses occur only while both the channel enable and glb_en_i are high. When both go high, the channel arms if the comparator is not all ones. Any comparator write while both are high arms the channel again at once.
- R12: A configuration write that requests level triggering raises err_o. err_o follows that bit at each configuration write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| count_i | input | 64 | Live main count |
| glb_en_i | input | 1 | Global enable for counting and event generation |
| wr_en_i | input | 1 | Write strobe |
| wr_sel_i | input | 2 | Write target: 0 configuration, 1 comparator low half, 2 comparator high half |
| wr_data_i | input | 32 | Write data |
| fire_o | output | 1 | One-clock event pulse |
| cmp_o | output | 64 | Comparator readback |
| cfg_o | output | 4 | Configuration readback: {32-bit, set-value, periodic, enable} |
| err_o | output | 1 | Level triggering was requested |

## Verification
The hardest situation to reach is the 32-bit one-shot wrap. It only appears when the comparator lies beyond the point where the low half of the count rolls over, and the count must then be walked across that rollover. The bench arms the channel with the count sixteen ticks short of the low-half wrap and a comparator of 0x10. It then steps the count one tick per clock and expects exactly one pulse at the wrap and a second pulse at the match. A second hard case is periodic catch-up, which is reached by jumping the count several periods past the comparator in one step. The bench then checks that only one pulse comes out and that the comparator ends a single period ahead of that count.

// File: rtl/cmp_channel.sv
module cmp_channel #(
  parameter int CW = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] count_i,
  input  logic          glb_en_i,
  input  logic          wr_en_i,
  input  logic [1:0]    wr_sel_i,
  input  logic [CW/2-1:0] wr_data_i,
  output logic          fire_o,
  output logic [CW-1:0] cmp_o,
  output logic [3:0]    cfg_o,
  output logic          err_o
);

  localparam int HW = CW / 2;
  localparam logic [1:0] SEL_CFG = 2'd0;
  localparam logic [1:0] SEL_LO  = 2'd1;
  localparam logic [1:0] SEL_HI  = 2'd2;
  localparam int B_EN = 0, B_PER = 1, B_SETV = 2, B_W32 = 3, B_LVL = 4;

  function automatic logic is_due(input logic [CW-1:0] tgt, input logic [CW-1:0] now,
                                  input logic w32);
    logic [CW-1:0] d;
    d = tgt - now;
    if (w32) return d[HW-1] || (d[HW-1:0] == '0);
    return d[CW-1] || (d == '0);
  endfunction

  logic [CW-1:0] cmp_q, prd_q, snap_q;
  logic en_q, per_q, setv_q, w32_q, err_q;
  logic armed_q, wrap_q, catch_q, act_q;

  logic wr_cfg, wr_lo, wr_hi, cmp_upd, active, arm_ev;
  logic fire_now, reload, catch_step, wrap_set;
  logic [CW-1:0] cmp_w, prd_w, cmp_nx, prd_nx, adv;
  logic [HW-1:0] d32, dpos;

  assign wr_cfg  = wr_en_i && (wr_sel_i == SEL_CFG);
  assign wr_lo   = wr_en_i && (wr_sel_i == SEL_LO);
  assign wr_hi   = wr_en_i && (wr_sel_i == SEL_HI);
  assign cmp_upd = !per_q || setv_q;
  assign active  = en_q && glb_en_i;

  always_comb begin
    cmp_w = cmp_q;
    prd_w = prd_q;
    if (wr_lo) begin
      if (cmp_upd) cmp_w[HW-1:0] = wr_data_i;
      if (per_q) prd_w[HW-1:0] = w32_q ? {1'b0, wr_data_i[HW-2:0]} : wr_data_i;
    end
    if (wr_hi && !w32_q) begin
      if (cmp_upd) cmp_w[CW-1:HW] = wr_data_i;
      else         prd_w[CW-1:HW] = {1'b0, wr_data_i[HW-2:0]};
    end
  end

  assign adv = w32_q ? {{HW{1'b0}}, cmp_q[HW-1:0] + prd_q[HW-1:0]} : cmp_q + prd_q;

  assign d32      = cmp_w[HW-1:0] - count_i[HW-1:0];
  assign dpos     = (d32[HW-1] || d32 == '0) ? '0 : d32;
  assign wrap_set = w32_q && !per_q && ((~count_i[HW-1:0]) < dpos);

  assign arm_ev = active && (wr_lo || wr_hi || (!act_q && cmp_q != '1));

  assign fire_now   = active && armed_q && !catch_q &&
                      (wrap_q ? (&count_i[HW-1:0]) : is_due(cmp_q, count_i, w32_q));
  assign reload     = fire_now && !wrap_q && per_q && (prd_q != '0);
  assign catch_step = catch_q && active && !arm_ev && is_due(cmp_q, snap_q, w32_q);

  always_comb begin
    cmp_nx = (!arm_ev && (reload || catch_step)) ? adv : cmp_w;
    prd_nx = prd_w;
    if (wr_cfg && wr_data_i[B_W32]) begin
      cmp_nx = {{HW{1'b0}}, cmp_nx[HW-1:0]};
      prd_nx = {{HW{1'b0}}, prd_nx[HW-1:0]};
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmp_q   <= '1;
      prd_q   <= '0;
      snap_q  <= '0;
      en_q    <= 1'b0;
      per_q   <= 1'b0;
      setv_q  <= 1'b0;
      w32_q   <= 1'b0;
      err_q   <= 1'b0;
      armed_q <= 1'b0;
      wrap_q  <= 1'b0;
      catch_q <= 1'b0;
      act_q   <= 1'b0;
      fire_o  <= 1'b0;
    end else begin
      fire_o <= fire_now;
      act_q  <= active;
      cmp_q  <= cmp_nx;
      prd_q  <= prd_nx;
      if (wr_cfg) begin
        en_q   <= wr_data_i[B_EN];
        per_q  <= wr_data_i[B_PER];
        setv_q <= wr_data_i[B_SETV];
        w32_q  <= wr_data_i[B_W32];
        err_q  <= wr_data_i[B_LVL];
      end else if (wr_lo || wr_hi) begin
        setv_q <= 1'b0;
      end
      if (arm_ev) begin
        armed_q <= 1'b1;
        wrap_q  <= wrap_set;
        catch_q <= 1'b0;
      end else if (!active) begin
        armed_q <= 1'b0;
        catch_q <= 1'b0;
      end else if (fire_now) begin
        if (wrap_q) wrap_q <= 1'b0;
        else if (reload) begin
          snap_q  <= count_i;
          catch_q <= 1'b1;
        end else armed_q <= 1'b0;
      end else if (catch_q && !catch_step) begin
        catch_q <= 1'b0;
      end
    end
  end

  assign cmp_o = cmp_q;
  assign cfg_o = {w32_q, setv_q, per_q, en_q};
  assign err_o = err_q;

  // R5
  setv_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && (wr_sel_i == SEL_LO || wr_sel_i == SEL_HI)) |=> !cfg_o[B_SETV]);

  // R4
  prd_msb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    prd_q[CW-1] == 1'b0);

  // R6
  trunc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_o[B_W32] |-> (cmp_o[CW-1:HW] == '0));

  // R12
  lvl_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && wr_sel_i == SEL_CFG && wr_data_i[B_LVL]) |=> err_o);

  // R9
  oneshot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fire_o && !cfg_o[B_PER] && !cfg_o[B_W32] && !$past(wr_en_i)) |=> !fire_o);

endmodule

// File: tb/cmp_channel_test.sv
`timescale 1ns/1ps
module cmp_channel_test;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [63:0] count_i;
  logic        glb_en_i;
  logic        wr_en_i;
  logic [1:0]  wr_sel_i;
  logic [31:0] wr_data_i;
  logic        fire_o;
  logic [63:0] cmp_o;
  logic [3:0]  cfg_o;
  logic        err_o;

  int checks = 0;
  int failures = 0;
  int fires = 0;

  always #2 clk = ~clk;

  cmp_channel uut (
    .clk(clk), .rst_n(rst_n), .count_i(count_i), .glb_en_i(glb_en_i),
    .wr_en_i(wr_en_i), .wr_sel_i(wr_sel_i), .wr_data_i(wr_data_i),
    .fire_o(fire_o), .cmp_o(cmp_o), .cfg_o(cfg_o), .err_o(err_o)
  );

  always @(negedge clk) if (rst_n && fire_o) fires++;

  // {w32, comparator, count, expected fires}
  localparam int NV = 9;
  localparam logic [130:0] VEC [NV] = '{
    {1'b0, 64'd1000,                64'd999,                 2'd0},
    {1'b0, 64'd1000,                64'd1000,                2'd1},
    {1'b0, 64'd1000,                64'd1001,                2'd1},
    {1'b0, 64'd0,                   64'h8000_0000_0000_0001, 2'd0},
    {1'b0, 64'h8000_0000_0000_0000, 64'd0,                   2'd1},
    {1'b1, 64'd5,                   64'h0000_0001_0000_0004, 2'd0},
    {1'b1, 64'd5,                   64'h0000_0007_0000_0005, 2'd1},
    {1'b1, 64'h10,                  64'h0000_0000_9000_0000, 2'd0},
    {1'b1, 64'h0000_0000_7FFF_FFFF, 64'h0000_0000_8000_0000, 2'd1}
  };

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] sel, input logic [31:0] data);
    @(negedge clk);
    wr_en_i = 1'b1; wr_sel_i = sel; wr_data_i = data;
    @(negedge clk);
    wr_en_i = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #800000;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rst_n = 1'b0; count_i = '0; glb_en_i = 1'b0;
    wr_en_i = 1'b0; wr_sel_i = '0; wr_data_i = '0;
    idle(3);
    rst_n = 1'b1;
    idle(4);
    check("R1 comparator after reset", cmp_o, 64'hFFFF_FFFF_FFFF_FFFF);
    check("R1 config after reset", {60'd0, cfg_o}, 64'd0);
    check("R1 error after reset", {63'd0, err_o}, 64'd0);
    check("R1 no fire after reset", fires, 0);

    for (int i = 0; i < NV; i++) begin
      glb_en_i = 1'b0;
      count_i  = VEC[i][65:2];
      wr(2'd0, {28'd0, VEC[i][130], 3'b001});
      wr(2'd2, VEC[i][129:98]);
      wr(2'd1, VEC[i][97:66]);
      idle(2);
      fires = 0;
      glb_en_i = 1'b1;
      idle(5);
      check($sformatf("R7 due vector %0d", i), fires, {62'd0, VEC[i][1:0]});
      glb_en_i = 1'b0;
      idle(2);
    end

    // R10: 32-bit one-shot, comparator beyond the low-half wrap
    glb_en_i = 1'b0;
    wr(2'd0, 32'h9);
    wr(2'd1, 32'h10);
    count_i = 64'h0000_0000_FFFF_FFF0;
    idle(2);
    fires = 0;
    glb_en_i = 1'b1;
    idle(1);
    for (int k = 0; k < 17; k++) begin
      count_i = count_i + 64'd1;
      @(negedge clk);
    end
    idle(2);
    check("R10 fire at low-half wrap", fires, 1);
    for (int k = 0; k < 30; k++) begin
      count_i = count_i + 64'd1;
      @(negedge clk);
    end
    check("R10 second fire at match", fires, 2);

    // R2 R5 R8: periodic, 64-bit
    glb_en_i = 1'b0;
    idle(2);
    wr(2'd0, 32'h7);
    wr(2'd2, 32'h0);
    check("R5 set-value cleared after write", {63'd0, cfg_o[2]}, 64'd0);
    wr(2'd0, 32'h7);
    wr(2'd1, 32'd100);
    check("R2 comparator low loaded with set-value", cmp_o, 64'd100);
    count_i = 64'd0;
    idle(2);
    fires = 0;
    glb_en_i = 1'b1;
    for (int k = 0; k < 350; k++) begin
      @(negedge clk);
      count_i = count_i + 64'd1;
    end
    idle(4);
    check("R8 periodic fire count", fires, 3);
    check("R8 comparator after reloads", cmp_o, 64'd400);

    fires = 0;
    count_i = 64'd1000;
    idle(15);
    check("R8 one fire on count jump", fires, 1);
    check("R8 catch-up ahead of count", cmp_o, 64'd1100);

    // R3: periodic without set-value
    glb_en_i = 1'b0;
    idle(2);
    wr(2'd0, 32'h3);
    wr(2'd1, 32'd55);
    check("R3 low write keeps comparator", cmp_o, 64'd1100);
    wr(2'd2, 32'd7);
    check("R3 high write keeps comparator", cmp_o, 64'd1100);
    wr(2'd2, 32'd0);
    count_i = 64'd1100;
    fires = 0;
    glb_en_i = 1'b1;
    idle(8);
    check("R3 period low loaded", cmp_o, 64'd1155);
    check("R3 fire with loaded period", fires, 1);

    // R4: clamp of bit 31 in 32-bit periodic
    glb_en_i = 1'b0;
    idle(2);
    wr(2'd0, 32'hF);
    wr(2'd1, 32'h8000_0010);
    count_i = 64'h0000_0000_8000_0010;
    glb_en_i = 1'b1;
    idle(8);
    check("R4 period bit 31 cleared", cmp_o, 64'h0000_0000_8000_0020);

    // R8: 32-bit sum wraps
    glb_en_i = 1'b0;
    idle(2);
    wr(2'd0, 32'hF);
    wr(2'd1, 32'hFFFF_FFF8);
    count_i = 64'h0000_0000_FFFF_FFF8;
    glb_en_i = 1'b1;
    idle(8);
    check("R8 32-bit reload wraps", cmp_o, 64'h0000_0000_7FFF_FFF0);

    // R2 R6: truncation and ignored high writes
    glb_en_i = 1'b0;
    idle(2);
    wr(2'd0, 32'h1);
    wr(2'd2, 32'h1234_5678);
    wr(2'd1, 32'h9ABC_DEF0);
    check("R2 both halves written", cmp_o, 64'h1234_5678_9ABC_DEF0);
    wr(2'd0, 32'h9);
    check("R6 truncation on 32-bit select", cmp_o, 64'h0000_0000_9ABC_DEF0);
    wr(2'd2, 32'hAAAA);
    check("R6 high write ignored in 32-bit", cmp_o, 64'h0000_0000_9ABC_DEF0);

    // R12
    wr(2'd0, 32'h11);
    check("R12 level request flagged", {63'd0, err_o}, 64'd1);
    wr(2'd0, 32'h1);
    check("R12 flag drops", {63'd0, err_o}, 64'd0);

    // R11 R9: enables and re-arming
    glb_en_i = 1'b0;
    wr(2'd0, 32'h0);
    wr(2'd2, 32'd0);
    wr(2'd1, 32'd50);
    count_i = 64'd60;
    idle(2);
    fires = 0;
    glb_en_i = 1'b1;
    idle(6);
    check("R11 no fire with channel disabled", fires, 0);
    wr(2'd0, 32'h1);
    idle(6);
    check("R11 fire after channel enabled", fires, 1);
    idle(10);
    check("R9 one-shot stays silent", fires, 1);
    wr(2'd1, 32'd55);
    idle(6);
    check("R11 comparator write re-arms", fires, 2);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule